// File: doc/BRIEF.md
# Converter Power Sequencer

This block decides when the core of a mixed-signal converter may run. An active-low power-down pin is the first gate: while it is low the control register file is held in reset and the core is off. When the pin rises, the registers become writable but the core stays in a low-power state. Software loads its settings with the run/stop bit at 1 and then clears the bit to start the core. Every time the core enters normal operation, the sequencer issues a one-cycle offset-calibration request.

While the core runs, two monitors watch its clocks from a free-running reference clock. The first detects a master clock that has stopped. The second detects a frame clock that no longer holds the expected ratio to the master clock. Either fault moves the core to standby without touching the register file. When the clocks are healthy again, the core returns to normal operation and is calibrated again.

The state machine has four states:

- OFF: held in reset by the pin.
- LOWPWR: registers live, core in reset.
- ACTIVE: core running.
- STANDBY: clock fault, registers kept.

Its transitions are:

- OFF→LOWPWR: always, on the first reference edge after the pin rises.
- LOWPWR→ACTIVE: run/stop bit is 0 and there is no fault. Issues a calibration request.
- LOWPWR→STANDBY: run/stop bit is 0 and a fault is present.
- ACTIVE→STANDBY: a fault appears.
- STANDBY→ACTIVE: the fault clears. Issues a calibration request.
- ACTIVE→LOWPWR and STANDBY→LOWPWR: run/stop bit is 1.

Top module: `conv_power_seq`

## Requirements
- R1: While `pdn_n` is low, `regs_rst` is 1 and `core_en`, `standby` and `cal_req` are 0, without waiting for a clock edge.
- R2: After `pdn_n` rises, `core_en` and `standby` stay 0 for as long as `run_stop` is 1, whether the clocks are healthy or faulty.
- R3: With healthy clocks, `core_en` is 1 in the cycle after the first reference edge that samples `run_stop` at 0.
- R4: `cal_req` is 1 for exactly one cycle, the first cycle of every period in which `core_en` is 1, and 0 otherwise.
- R5: A reference edge that samples `run_stop` at 1 clears `core_en` for the next cycle, and this issues no calibration request.
- R6: Master-clock rising edges spaced fewer than `STALL_CYC` reference cycles apart cause no standby.
- R7: A gap of `STALL_CYC` or more reference cycles without a master-clock rising edge moves a running core to standby: `standby` is 1 and `core_en` is 0.
- R8: Standby is entered when two consecutive frame-clock periods (rising edge to rising edge) each hold a number of master-clock rising edges other than `FRAME_RATIO`. A single odd period causes no standby.
- R9: When the fault clears while `run_stop` is 0, the core leaves standby with `core_en` at 1 and exactly one `cal_req` pulse.
- R10: `regs_rst` stays 0 throughout standby, so register contents are kept.
- R11: A reference edge that samples `run_stop` at 1 during standby returns the block to low power, with `standby` and `core_en` both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| pdn_n | input | 1 | Power-down pin, active low, asynchronous |
| mclk | input | 1 | Master clock, sampled via two-flop synchroniser |
| lrck | input | 1 | Frame clock, sampled via two-flop synchroniser |
| run_stop | input | 1 | Register bit: 1 holds the core in low power |
| regs_rst | output | 1 | Reset for the control register file |
| core_en | output | 1 | Core running; 0 means low power or standby |
| standby | output | 1 | Core parked because of a clock fault |
| cal_req | output | 1 | One-cycle offset-calibration request |

## Verification
The stall monitor is swept over master-clock pauses on both sides of the timeout. Short pauses must leave the core running with no calibration, which separates a correct threshold from one that is too eager. Long pauses must produce standby followed by exactly one calibration, which separates correct recovery from a missing or repeated pulse. The frame monitor is swept over every half-period from 2 to 6 master-clock cycles: only the matching ratio may keep the core running. A single stretched frame checks that one odd period is tolerated. The run/stop bit is toggled from low power, from the running state and from standby, and the output edges are sampled at the exact cycle.

// File: rtl/cps_pkg.sv
package cps_pkg;
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_LOWPWR  = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_STANDBY = 2'd3
    } cps_state_t;
endpackage

// File: rtl/cps_sync2.sv
module cps_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cps_stall_mon.sv
module cps_stall_mon #(
    parameter int STALL_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_s,
    output logic stall
);
    localparam int CW = $clog2(STALL_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(STALL_CYC);

    logic          prev_q;
    logic [CW-1:0] gap_q;
    logic          rise;

    assign rise = mclk_s & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            gap_q  <= '0;
        end else begin
            prev_q <= mclk_s;
            if (rise)
                gap_q <= '0;
            else if (gap_q != LIM)
                gap_q <= gap_q + 1'b1;
        end
    end

    assign stall = (gap_q == LIM);
endmodule

// File: rtl/cps_frame_mon.sv
module cps_frame_mon #(
    parameter int FRAME_RATIO = 256,
    parameter int MISS_LIM    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_s,
    input  logic lrck_s,
    output logic desync
);
    localparam int CW = $clog2(2 * FRAME_RATIO + 2);
    localparam int MW = $clog2(MISS_LIM + 1);
    localparam logic [CW-1:0] EXP  = CW'(FRAME_RATIO);
    localparam logic [CW-1:0] CMAX = '1;
    localparam logic [MW-1:0] MLIM = MW'(MISS_LIM);

    logic          mprev_q, lprev_q;
    logic [CW-1:0] cnt_q;
    logic [MW-1:0] miss_q;
    logic          mrise, lrise;

    assign mrise = mclk_s & ~mprev_q;
    assign lrise = lrck_s & ~lprev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mprev_q <= 1'b0;
            lprev_q <= 1'b0;
            cnt_q   <= '0;
            miss_q  <= '0;
        end else begin
            mprev_q <= mclk_s;
            lprev_q <= lrck_s;
            if (lrise) begin
                cnt_q <= mrise ? CW'(1) : '0;
                if (cnt_q == EXP)
                    miss_q <= '0;
                else if (miss_q != MLIM)
                    miss_q <= miss_q + 1'b1;
            end else if (mrise && cnt_q != CMAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign desync = (miss_q == MLIM);
endmodule

// File: rtl/conv_power_seq.sv
module conv_power_seq
    import cps_pkg::*;
#(
    parameter int STALL_CYC   = 1250,
    parameter int FRAME_RATIO = 256,
    parameter int MISS_LIM    = 2
) (
    input  logic clk,
    input  logic pdn_n,
    input  logic mclk,
    input  logic lrck,
    input  logic run_stop,
    output logic regs_rst,
    output logic core_en,
    output logic standby,
    output logic cal_req
);
    logic [1:0] clk_s;
    logic       stall, desync, fault;
    cps_state_t state_q, state_d;
    logic       was_active_q;

    cps_sync2 #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (pdn_n),
        .d     ({lrck, mclk}),
        .q     (clk_s)
    );

    cps_stall_mon #(.STALL_CYC(STALL_CYC)) u_stall (
        .clk    (clk),
        .rst_n  (pdn_n),
        .mclk_s (clk_s[0]),
        .stall  (stall)
    );

    cps_frame_mon #(.FRAME_RATIO(FRAME_RATIO), .MISS_LIM(MISS_LIM)) u_frame (
        .clk    (clk),
        .rst_n  (pdn_n),
        .mclk_s (clk_s[0]),
        .lrck_s (clk_s[1]),
        .desync (desync)
    );

    assign fault = stall | desync;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:     state_d = ST_LOWPWR;
            ST_LOWPWR:  if (!run_stop) state_d = fault ? ST_STANDBY : ST_ACTIVE;
            ST_ACTIVE:  if (run_stop) state_d = ST_LOWPWR;
                        else if (fault) state_d = ST_STANDBY;
            ST_STANDBY: if (run_stop) state_d = ST_LOWPWR;
                        else if (!fault) state_d = ST_ACTIVE;
            default:    state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) begin
            state_q      <= ST_OFF;
            was_active_q <= 1'b0;
        end else begin
            state_q      <= state_d;
            was_active_q <= (state_q == ST_ACTIVE);
        end
    end

    always_comb begin
        regs_rst = !pdn_n;
        core_en  = (state_q == ST_ACTIVE);
        standby  = (state_q == ST_STANDBY);
        cal_req  = (state_q == ST_ACTIVE) && !was_active_q;
    end
endmodule

// File: rtl/cps_checker.sv
module cps_checker (
    input logic clk,
    input logic pdn_n,
    input logic run_stop,
    input logic core_en,
    input logic standby,
    input logic cal_req
);
    a_r5_stop_lowers_core: assert property (@(posedge clk) disable iff (!pdn_n)
        run_stop |=> !core_en);

    a_r4_cal_one_cycle: assert property (@(posedge clk) disable iff (!pdn_n)
        cal_req |=> !cal_req);

    a_r4_cal_with_core: assert property (@(posedge clk) disable iff (!pdn_n)
        cal_req |-> core_en);

    a_r4_rise_has_cal: assert property (@(posedge clk) disable iff (!pdn_n)
        $rose(core_en) |-> cal_req);

    a_r7_standby_excl: assert property (@(posedge clk) disable iff (!pdn_n)
        !(standby && core_en));

    a_r11_stop_from_standby: assert property (@(posedge clk) disable iff (!pdn_n)
        (standby && run_stop) |=> !standby);
endmodule

bind conv_power_seq cps_checker u_cps_checker (
    .clk      (clk),
    .pdn_n    (pdn_n),
    .run_stop (run_stop),
    .core_en  (core_en),
    .standby  (standby),
    .cal_req  (cal_req)
);

// File: tb/tb_conv_power_seq.sv
module tb_conv_power_seq;
    localparam int STALL = 20;
    localparam int RATIO = 8;

    logic clk = 1'b0;
    logic pdn_n = 1'b0;
    logic mclk = 1'b0;
    logic lrck = 1'b0;
    logic run_stop = 1'b1;
    logic mclk_run = 1'b1;
    int   lr_half = RATIO / 2;
    logic stretch_req = 1'b0;
    logic stretch_ack = 1'b0;
    int   div = 0;
    logic regs_rst, core_en, standby, cal_req;

    int n_chk = 0;
    int n_pass = 0;
    int tot_cal = 0;
    int tot_sb = 0;
    int tot_rr_sb = 0;

    conv_power_seq #(.STALL_CYC(STALL), .FRAME_RATIO(RATIO), .MISS_LIM(2)) dut (
        .clk      (clk),
        .pdn_n    (pdn_n),
        .mclk     (mclk),
        .lrck     (lrck),
        .run_stop (run_stop),
        .regs_rst (regs_rst),
        .core_en  (core_en),
        .standby  (standby),
        .cal_req  (cal_req)
    );

    always #4 clk = ~clk;

    initial begin
        #3;
        forever begin
            #16;
            if (mclk_run) mclk = ~mclk;
        end
    end

    always @(negedge mclk) begin
        if (div >= lr_half - 1) begin
            lrck <= ~lrck;
            if (stretch_req != stretch_ack) begin
                stretch_ack <= stretch_req;
                div <= -1;
            end else begin
                div <= 0;
            end
        end else begin
            div <= div + 1;
        end
    end

    always @(negedge clk) begin
        tot_cal   <= tot_cal + int'(cal_req);
        tot_sb    <= tot_sb + int'(standby);
        tot_rr_sb <= tot_rr_sb + int'(standby && regs_rst);
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act == exp) n_pass++;
        else $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(64'd200000 * 8);
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_pass, n_chk + 1);
        $finish;
    end

    initial begin
        int c0, s0, r0;
        wait_cyc(5);
        // R1 reset state
        chk("R1 regs_rst", int'(regs_rst), 1);
        chk("R1 core_en", int'(core_en), 0);
        chk("R1 standby", int'(standby), 0);
        chk("R1 cal_req", int'(cal_req), 0);
        pdn_n = 1'b1;
        wait_cyc(200);
        chk("R2 core_en lowpwr", int'(core_en), 0);
        chk("R2 regs_rst released", int'(regs_rst), 0);
        // R2 fault while in low power
        mclk_run = 1'b0;
        wait_cyc(60);
        chk("R2 standby during stall in lowpwr", int'(standby), 0);
        chk("R2 core_en during stall in lowpwr", int'(core_en), 0);
        mclk_run = 1'b1;
        wait_cyc(200);
        // R3/R4 start
        run_stop = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R3 core_en after clear", int'(core_en), 1);
        chk("R4 cal_req first cycle", int'(cal_req), 1);
        @(negedge clk);
        chk("R4 cal_req second cycle", int'(cal_req), 0);
        // R6 short pauses
        for (int p = 2; p <= 8; p = p * 2) begin
            c0 = tot_cal; s0 = tot_sb;
            mclk_run = 1'b0;
            wait_cyc(p);
            mclk_run = 1'b1;
            wait_cyc(150);
            chk($sformatf("R6 no standby pause %0d", p), tot_sb - s0, 0);
            chk($sformatf("R6 no cal pause %0d", p), tot_cal - c0, 0);
            chk($sformatf("R6 core_en pause %0d", p), int'(core_en), 1);
        end
        // R7/R9/R10 long pauses
        for (int p = 40; p <= 80; p = p + 20) begin
            c0 = tot_cal; r0 = tot_rr_sb;
            mclk_run = 1'b0;
            wait_cyc(p);
            chk($sformatf("R7 standby pause %0d", p), int'(standby), 1);
            chk($sformatf("R7 core_en pause %0d", p), int'(core_en), 0);
            mclk_run = 1'b1;
            wait_cyc(200);
            chk($sformatf("R9 core_en after pause %0d", p), int'(core_en), 1);
            chk($sformatf("R9 one cal after pause %0d", p), tot_cal - c0, 1);
            chk($sformatf("R10 regs_rst in standby %0d", p), tot_rr_sb - r0, 0);
        end
        // R8 frame ratio sweep
        for (int h = 2; h <= 6; h++) begin
            c0 = tot_cal;
            lr_half = h;
            wait_cyc(600);
            chk($sformatf("R8 standby half %0d", h), int'(standby), (h != RATIO / 2) ? 1 : 0);
            chk($sformatf("R8 core_en half %0d", h), int'(core_en), (h == RATIO / 2) ? 1 : 0);
            lr_half = RATIO / 2;
            wait_cyc(600);
            chk($sformatf("R9 core_en restored half %0d", h), int'(core_en), 1);
            chk($sformatf("R9 cal count half %0d", h), tot_cal - c0, (h != RATIO / 2) ? 1 : 0);
        end
        // R8 single odd frame
        c0 = tot_cal; s0 = tot_sb;
        stretch_req = ~stretch_req;
        wait_cyc(600);
        chk("R8 single odd frame no standby", tot_sb - s0, 0);
        chk("R8 single odd frame no cal", tot_cal - c0, 0);
        // R11 stop from standby
        lr_half = 3;
        wait_cyc(600);
        chk("R11 in standby", int'(standby), 1);
        run_stop = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R11 standby cleared", int'(standby), 0);
        chk("R11 core_en low", int'(core_en), 0);
        lr_half = RATIO / 2;
        wait_cyc(600);
        chk("R2 stays lowpwr after recovery", int'(core_en), 0);
        run_stop = 1'b0;
        wait_cyc(5);
        chk("R3 core_en restart", int'(core_en), 1);
        // R5 stop from active
        c0 = tot_cal;
        run_stop = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R5 core_en cleared", int'(core_en), 0);
        wait_cyc(20);
        chk("R5 no cal on stop", tot_cal - c0, 0);
        // R1 power-down mid operation
        run_stop = 1'b0;
        wait_cyc(10);
        #1 pdn_n = 1'b0;
        #1;
        chk("R1 regs_rst async", int'(regs_rst), 1);
        chk("R1 core_en async", int'(core_en), 0);
        chk("R1 cal_req async", int'(cal_req), 0);
        run_stop = 1'b1;
        wait_cyc(5);
        pdn_n = 1'b1;
        wait_cyc(50);
        chk("R2 lowpwr after repower", int'(core_en), 0);
        $display("%0d/%0d checks passed", n_pass, n_chk);
        $finish;
    end
endmodule